// File: doc/BRIEF.md
# Processor Reset Supervisor

This block holds a host processor in reset whenever one of three conditions calls for it. A supply-low indication from an external comparator holds reset for as long as it lasts, and then for a fixed stretch after the supply recovers. A watchdog expiry causes a fixed-length reset pulse, but only when the watchdog is enabled. The shared reset pin also serves as a manual-reset input: a debounced low on it causes the same fixed-length pulse. The pulse length and the debounce length are counted in millisecond ticks.

The block records why it reset the processor in two sticky flags, one for the supply and one for the watchdog. A manual reset sets neither flag, so an empty flag pair after a reset points to the button. The flags stay set until the host clears them. Reset also raises a bus-lockout signal for the serial host interface. If the supply drops while a memory transfer is in flight, that transfer is allowed to finish before lockout takes effect. When each reset pulse ends, the block sends a one-cycle restart to the watchdog. It also holds the 2-bit supply trip-point select that the analog comparator uses.

The controller has three states. RUN means reset is released. SUPPLY_LOW means the supply is below the trip point. HOLD means a fixed-length reset stretch is being counted. The transitions are:
- RUN to SUPPLY_LOW on supply low.
- RUN to HOLD on an enabled watchdog expiry or a debounced manual press.
- SUPPLY_LOW to HOLD when the supply recovers.
- HOLD to SUPPLY_LOW on supply low.
- HOLD to RUN when the stretch count completes.

Top module: `rst_supervisor`

## Requirements
- R1: While `vdd_low` is high, `rst_out_n` is low from the cycle after `vdd_low` is first sampled high, and it stays low.
- R2: After `vdd_low` clears, `rst_out_n` stays low through PULSE_MS-1 further `ms_tick` pulses. It goes high on the edge that takes the PULSE_MS-th tick. Ticks are counted from the cycle after the clear is sampled.
- R3: A `wdt_expire` pulse with `wdt_en` high, taken while reset is released, drives `rst_out_n` low on the next cycle for PULSE_MS ticks and sets `flag_wdt`. An expiry with `wdt_en` low changes neither `rst_out_n` nor `flag_wdt`.
- R4: `mr_pin_n` must be sampled low, after a two-flop synchronizer, at DEB_MS consecutive ticks to start a PULSE_MS-tick reset. A low that lasts fewer ticks causes no reset.
- R5: A manual reset sets no flag. A press held past the end of its pulse gives no second pulse, and the block ignores its own driven-low pin while a pulse runs.
- R6: A supply-low condition sets `flag_por`. Both flags can be set at once, and each stays set until it is cleared.
- R7: `flag_clr[1]` clears `flag_wdt` and `flag_clr[0]` clears `flag_por`. A set condition in the same cycle wins over the clear.
- R8: `bus_lock` is high whenever `rst_out_n` is low. There is one exception: when a supply-low reset starts from RUN while `xfer_busy` is high, `bus_lock` stays low until `xfer_busy` falls.
- R9: `wdt_restart` is high for exactly the one cycle in which `rst_out_n` returns high.
- R10: `trip_we` loads `trip_din` into `trip_sel` on the next cycle. The codes 00, 01, 10 and 11 select trip points of 2.6 V, 2.9 V, 3.9 V and 4.4 V.
- R11: After `rst_n`, the outputs are: `rst_out_n` 1, `bus_lock` 0, both flags 0, `wdt_restart` 0, `trip_sel` 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| vdd_low | input | 1 | Supply below trip point (synchronous) |
| wdt_expire | input | 1 | One-cycle watchdog timeout request |
| wdt_en | input | 1 | Watchdog may cause resets |
| mr_pin_n | input | 1 | Raw level of the shared reset pin |
| flag_clr | input | 2 | Clear strobes: bit 1 watchdog flag, bit 0 supply flag |
| xfer_busy | input | 1 | A memory transfer is in progress |
| trip_we | input | 1 | Write strobe for the trip-point select |
| trip_din | input | 2 | New trip-point code |
| rst_out_n | output | 1 | Active-low processor reset |
| bus_lock | output | 1 | Serial host access is blocked |
| flag_wdt | output | 1 | Sticky: watchdog caused a reset |
| flag_por | output | 1 | Sticky: supply-low caused a reset |
| wdt_restart | output | 1 | One-cycle restart pulse to the watchdog |
| trip_sel | output | 2 | Current trip-point code |

## Verification
The supply path is tested with a long low period, so that hold-while-low and the post-recovery stretch each show up separately. An exact count of PULSE_MS-1 ticks against PULSE_MS ticks exposes a stretch that is off by one. Watchdog expiries are tried both enabled and disabled, which separates gating by `wdt_en` from flag setting. The manual pin is tried three ways: a glitch one tick too short, a full press, and a press held past the end of the pulse. Together these separate the debounce, the flag-free encoding and the one-pulse-per-press latch. Two further patterns cover the flags and lockout. Flag clears are mixed with overlapping sets to show the two flags are independent and that a set wins over a clear. A supply drop during a busy transfer separates deferred lockout from immediate lockout.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_SUPPLY_LOW = 2'd1,
        ST_HOLD       = 2'd2
    } rs_state_t;

    localparam int TRIP_W = 2;
    localparam int NFLAG  = 2;
    localparam int FLAG_POR_IDX = 0;
    localparam int FLAG_WDT_IDX = 1;
endpackage

// File: rtl/rs_debounce.sv
module rs_debounce #(
    parameter int DEB_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin_n,
    input  logic mask,
    output logic fire
);
    localparam int CW = $clog2(DEB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    logic          sync1, sync2;
    logic [CW-1:0] cnt;
    logic          latched;
    logic          low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= pin_n;
            sync2 <= sync1;
        end
    end

    assign low  = ~sync2;
    assign fire = tick && low && !mask && !latched && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            latched <= 1'b0;
        end else if (!low) begin
            cnt     <= '0;
            latched <= 1'b0;
        end else if (mask) begin
            cnt <= '0;
        end else if (fire) begin
            cnt     <= '0;
            latched <= 1'b1;
        end else if (tick && !latched && cnt < LAST) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rs_tick_counter.sv
module rs_tick_counter #(
    parameter int LEN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    assign done = run && tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (!run) cnt <= '0;
        else if (tick) cnt <= done ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/rs_flags.sv
module rs_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int PULSE_MS = 100,
    parameter int DEB_MS   = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       vdd_low,
    input  logic       wdt_expire,
    input  logic       wdt_en,
    input  logic       mr_pin_n,
    input  logic [1:0] flag_clr,
    input  logic       xfer_busy,
    input  logic       trip_we,
    input  logic [1:0] trip_din,
    output logic       rst_out_n,
    output logic       bus_lock,
    output logic       flag_wdt,
    output logic       flag_por,
    output logic       wdt_restart,
    output logic [1:0] trip_sel
);
    import rs_pkg::*;

    rs_state_t               state, next;
    logic                    hold_done;
    logic                    mr_fire;
    logic                    wdt_fire;
    logic                    restart_q;
    logic                    grace_q;
    logic [TRIP_W-1:0]       trip_q;
    logic [NFLAG-1:0]        flag_set, flag_q;

    rs_debounce #(.DEB_TICKS(DEB_MS)) u_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ms_tick),
        .pin_n (mr_pin_n),
        .mask  (state != ST_RUN),
        .fire  (mr_fire)
    );

    rs_tick_counter #(.LEN(PULSE_MS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_HOLD),
        .tick  (ms_tick),
        .done  (hold_done)
    );

    assign wdt_fire = (state == ST_RUN) && !vdd_low && wdt_expire && wdt_en;

    always_comb begin
        flag_set               = '0;
        flag_set[FLAG_POR_IDX] = vdd_low;
        flag_set[FLAG_WDT_IDX] = wdt_fire;
    end

    rs_flags #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   ({flag_clr[1], flag_clr[0]}),
        .q     (flag_q)
    );

    always_comb begin
        next = state;
        unique case (state)
            ST_RUN: begin
                if (vdd_low)                  next = ST_SUPPLY_LOW;
                else if (wdt_fire || mr_fire) next = ST_HOLD;
            end
            ST_SUPPLY_LOW: begin
                if (!vdd_low)                 next = ST_HOLD;
            end
            ST_HOLD: begin
                if (vdd_low)                  next = ST_SUPPLY_LOW;
                else if (hold_done)           next = ST_RUN;
            end
            default:                          next = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            restart_q <= 1'b0;
            grace_q   <= 1'b0;
            trip_q    <= '0;
        end else begin
            state     <= next;
            restart_q <= (state == ST_HOLD) && (next == ST_RUN);
            if (state == ST_RUN && vdd_low) grace_q <= xfer_busy;
            else                            grace_q <= grace_q && xfer_busy;
            if (trip_we) trip_q <= trip_din;
        end
    end

    always_comb begin
        rst_out_n   = (state == ST_RUN);
        bus_lock    = (state != ST_RUN) && !grace_q;
        wdt_restart = restart_q;
        flag_wdt    = flag_q[FLAG_WDT_IDX];
        flag_por    = flag_q[FLAG_POR_IDX];
        trip_sel    = trip_q;
    end
endmodule

// File: rtl/rs_supervisor_chk.sv
module rs_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vdd_low,
    input logic       wdt_en,
    input logic [1:0] flag_clr,
    input logic       trip_we,
    input logic [1:0] trip_din,
    input logic       rst_out_n,
    input logic       bus_lock,
    input logic       flag_wdt,
    input logic       flag_por,
    input logic       wdt_restart,
    input logic [1:0] trip_sel
);
    assert_supply_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_low |=> !rst_out_n);

    assert_wdt_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_wdt) |-> $past(wdt_en));

    assert_por_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_low |=> flag_por);

    assert_por_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_por) |-> $past(flag_clr[0]));

    assert_wdt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_wdt) |-> $past(flag_clr[1]));

    assert_lock_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |-> !rst_out_n);

    assert_restart_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> wdt_restart);

    assert_restart_only_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_restart |-> $rose(rst_out_n));

    assert_trip_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trip_we |=> (trip_sel == $past(trip_din)));
endmodule

bind rst_supervisor rs_supervisor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vdd_low     (vdd_low),
    .wdt_en      (wdt_en),
    .flag_clr    (flag_clr),
    .trip_we     (trip_we),
    .trip_din    (trip_din),
    .rst_out_n   (rst_out_n),
    .bus_lock    (bus_lock),
    .flag_wdt    (flag_wdt),
    .flag_por    (flag_por),
    .wdt_restart (wdt_restart),
    .trip_sel    (trip_sel)
);

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
    localparam int PULSE = 5;
    localparam int DEB   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       vdd_low = 1'b0;
    logic       wdt_expire = 1'b0;
    logic       wdt_en = 1'b0;
    logic       btn_n = 1'b1;
    logic [1:0] flag_clr = 2'b00;
    logic       xfer_busy = 1'b0;
    logic       trip_we = 1'b0;
    logic [1:0] trip_din = 2'b00;
    logic       rst_out_n, bus_lock, flag_wdt, flag_por, wdt_restart;
    logic [1:0] trip_sel;
    logic       mr_pin_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign mr_pin_n = btn_n & rst_out_n;

    rst_supervisor #(.PULSE_MS(PULSE), .DEB_MS(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .vdd_low(vdd_low),
        .wdt_expire(wdt_expire), .wdt_en(wdt_en), .mr_pin_n(mr_pin_n),
        .flag_clr(flag_clr), .xfer_busy(xfer_busy), .trip_we(trip_we),
        .trip_din(trip_din), .rst_out_n(rst_out_n), .bus_lock(bus_lock),
        .flag_wdt(flag_wdt), .flag_por(flag_por), .wdt_restart(wdt_restart),
        .trip_sel(trip_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic clear_flags();
        flag_clr = 2'b11;
        step(1);
        flag_clr = 2'b00;
    endtask

    task automatic test_reset_state();
        check("R11 rst_out_n", rst_out_n, 1);
        check("R11 bus_lock", bus_lock, 0);
        check("R11 flag_wdt", flag_wdt, 0);
        check("R11 flag_por", flag_por, 0);
        check("R11 wdt_restart", wdt_restart, 0);
        check("R11 trip_sel", trip_sel, 0);
    endtask

    task automatic test_supply();
        vdd_low = 1'b1;
        step(1);
        check("R1 reset on supply low", rst_out_n, 0);
        check("R8 lock on supply low", bus_lock, 1);
        check("R6 supply flag set", flag_por, 1);
        tick(PULSE + 2);
        check("R1 reset held while low", rst_out_n, 0);
        vdd_low = 1'b0;
        step(1);
        tick(PULSE - 1);
        check("R2 reset still held", rst_out_n, 0);
        ms_tick = 1'b1;
        step(1);
        ms_tick = 1'b0;
        check("R2 reset released", rst_out_n, 1);
        check("R9 restart pulse", wdt_restart, 1);
        check("R8 lock released", bus_lock, 0);
        step(1);
        check("R9 restart one cycle", wdt_restart, 0);
        check("R6 supply flag sticky", flag_por, 1);
    endtask

    task automatic test_wdt();
        flag_clr = 2'b01;
        step(1);
        flag_clr = 2'b00;
        check("R7 supply flag cleared", flag_por, 0);
        wdt_en = 1'b0;
        wdt_expire = 1'b1;
        step(1);
        wdt_expire = 1'b0;
        check("R3 disabled expiry no reset", rst_out_n, 1);
        check("R3 disabled expiry no flag", flag_wdt, 0);
        wdt_en = 1'b1;
        wdt_expire = 1'b1;
        step(1);
        wdt_expire = 1'b0;
        check("R3 enabled expiry resets", rst_out_n, 0);
        check("R3 wdt flag set", flag_wdt, 1);
        check("R6 supply flag untouched", flag_por, 0);
        tick(PULSE - 1);
        check("R3 pulse still low", rst_out_n, 0);
        tick(1);
        check("R3 pulse ended", rst_out_n, 1);
        wdt_en = 1'b0;
    endtask

    task automatic test_flags();
        vdd_low = 1'b1;
        step(2);
        vdd_low = 1'b0;
        step(1);
        tick(PULSE);
        check("R6 both flags wdt", flag_wdt, 1);
        check("R6 both flags por", flag_por, 1);
        flag_clr = 2'b10;
        step(1);
        flag_clr = 2'b00;
        check("R7 wdt cleared", flag_wdt, 0);
        check("R7 por kept", flag_por, 1);
        vdd_low = 1'b1;
        flag_clr = 2'b01;
        step(1);
        flag_clr = 2'b00;
        check("R7 set wins over clear", flag_por, 1);
        vdd_low = 1'b0;
        step(1);
        tick(PULSE);
        clear_flags();
        check("R7 cleared after release", flag_por, 0);
    endtask

    task automatic test_manual_glitch();
        btn_n = 1'b0;
        step(3);
        tick(DEB - 1);
        btn_n = 1'b1;
        step(3);
        check("R4 short low ignored", rst_out_n, 1);
        btn_n = 1'b0;
        step(3);
        tick(DEB - 1);
        check("R4 count restarted", rst_out_n, 1);
        btn_n = 1'b1;
        step(3);
    endtask

    task automatic test_manual();
        btn_n = 1'b0;
        step(3);
        tick(DEB);
        check("R4 debounced press resets", rst_out_n, 0);
        check("R5 no wdt flag", flag_wdt, 0);
        check("R5 no por flag", flag_por, 0);
        tick(PULSE - 1);
        check("R4 pulse length", rst_out_n, 0);
        tick(1);
        check("R4 pulse ended", rst_out_n, 1);
        tick(DEB + 2);
        check("R5 held press one pulse", rst_out_n, 1);
        btn_n = 1'b1;
        step(3);
    endtask

    task automatic test_grace();
        xfer_busy = 1'b1;
        vdd_low = 1'b1;
        step(1);
        check("R8 reset during transfer", rst_out_n, 0);
        check("R8 lock deferred", bus_lock, 0);
        xfer_busy = 1'b0;
        step(1);
        check("R8 lock after transfer", bus_lock, 1);
        vdd_low = 1'b0;
        step(1);
        tick(PULSE);
        check("R8 release", bus_lock, 0);
        clear_flags();
    endtask

    task automatic test_trip();
        for (int c = 0; c < 4; c++) begin
            trip_din = 2'(c);
            trip_we = 1'b1;
            step(1);
            trip_we = 1'b0;
            check("R10 trip code", trip_sel, c);
        end
        trip_din = 2'b00;
        step(1);
        check("R10 held without write", trip_sel, 3);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        test_reset_state();
        test_supply();
        test_wdt();
        test_flags();
        test_manual_glitch();
        test_manual();
        test_grace();
        test_trip();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule